// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits between a requester and an asynchronous NOR flash device. It accepts one high-level request at a time and turns it into the command writes the device expects. The requests are: program one word, program a burst of words through the device's write buffer, erase a block, set a block lock, clear all locks, suspend and resume. After the command writes it reads the status register until the device reports ready, then decodes the error bits in a fixed priority and reports a three-bit result code with a one-cycle `done` pulse.

The flash side is a plain chip-enable / output-enable / write-enable bus with separate data-out, data-in and data-drive-enable signals. Every bus cycle is built from clock counts: one setup clock with chip enable low, a pulse of `WE_CYC` clocks for writes (or `RD_CYC` clocks of output enable for reads), then one hold clock. Burst data comes from a small buffer owned by the requester, which is indexed by the sequencer through `buf_idx`. A suspend request is taken only while an interruptible operation is polling, and a suspended operation can then only be resumed.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `done` is 0, `err_code` is 0 (OK) and `req_ready` is 1.
- R2: A word-program request (op 0) writes 40h and then the data word, both to the request address. It then reads status until bit 7 is 1, performs the status check, and pulses `done`.
- R3: An erase request (op 2) writes 20h and then D0h to the block address. It then polls status bit 7 until it is 1.
- R4: A lock-set request (op 5) writes 60h and then 01h. A clear-all-locks request (op 6) writes 60h and then D0h. Each is followed by polling and the status check.
- R5: A buffered-program request (op 1) with length N (1..BUF_WORDS) writes E8h to the block address and reads the extended status. It repeats this pair until bit 7 of the extended status reads 1. It then writes N-1, then buffer words 0..N-1 to addresses base+0..base+N-1, then D0h, and then polls.
- R6: If extended-status bit 7 is still 0 after BUF_TRIES E8h writes, the request ends with code 6 (timeout).
- R7: The status check maps status bits to `err_code` in this priority. Bits 4 and 5 both set gives 2 (command sequence). Otherwise, bit 3 gives 1 (voltage low), then bit 5 gives 3 (erase), then bit 4 gives 4 (program), then bit 1 gives 5 (locked). If none of these is set, the code is 0.
- R8: After any code other than 0 and 7, the sequencer writes 50h and then FFh before `done`. A code-0 result adds no writes after polling.
- R9: A suspend request (op 3) is accepted only in the cycle where a status read of a word, buffered or erase operation returns bit 7 = 0. The sequencer then writes B0h, polls, and if status bit 6 or bit 2 is 1, writes FFh and reports code 7. While suspended, only a resume (op 4) is accepted. A poll that returns ready in the same cycle as a pending suspend completes the operation instead.
- R10: A resume request while suspended writes D0h to the saved block address and returns to polling. It reports the final status of the original operation.
- R11: Each bus write holds `fl_we_n` low for exactly WE_CYC clocks. Chip enable is low one clock before and one clock after the pulse, and address and data stay stable while chip enable is low.
- R12: A suspend request with nothing polling, or a resume request with nothing suspended, produces no command other than 50h then FFh and reports code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Request kind: 0 word, 1 buffered, 2 erase, 3 suspend, 4 resume, 5 lock set, 6 lock clear |
| req_addr | input | AW | Word or block address |
| req_data | input | DW | Data word for word program |
| req_len | input | LW | Word count for buffered program |
| req_ready | output | 1 | Request taken on this clock when valid |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code, valid with done |
| buf_idx | output | LW | Index of the buffer word to supply |
| buf_data | input | DW | Buffer word at buf_idx |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_o | output | DW | Write data toward flash |
| fl_dq_oe | output | 1 | Data drive enable |
| fl_dq_i | input | DW | Read data from flash |

## Verification
The two functions that can meet in one cycle are suspend acceptance and poll completion. Both are decided when a status read finishes, so a suspend held pending while a poll returns ready must lose. The bench holds a suspend request valid while a word program runs whose first poll already reports ready. It then judges the result by the write log: no B0h appears, the program finishes with code 0, and the still-pending suspend is taken afterwards from idle and answered with code 2 and the 50h/FFh cleanup. A second case lets the suspend win against a long erase, checks the B0h/FFh sequence and code 7, and confirms that only a resume is then accepted.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [2:0] {
        OP_PROG     = 3'd0,
        OP_BUFPROG  = 3'd1,
        OP_ERASE    = 3'd2,
        OP_SUSPEND  = 3'd3,
        OP_RESUME   = 3'd4,
        OP_LOCK_SET = 3'd5,
        OP_LOCK_CLR = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        E_OK        = 3'd0,
        E_VPP       = 3'd1,
        E_CMDSEQ    = 3'd2,
        E_ERASE     = 3'd3,
        E_PROG      = 3'd4,
        E_LOCKED    = 3'd5,
        E_TIMEOUT   = 3'd6,
        E_SUSPENDED = 3'd7
    } err_e;

    typedef enum logic [1:0] {
        B_IDLE, B_SETUP, B_ACT, B_HOLD
    } bus_st_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_CMD2, S_POLL, S_CHECK, S_XSR, S_BCNT, S_BDATA,
        S_SUSP, S_SPOLL, S_RESUME, S_CLR, S_ARRAY, S_DONE
    } ctrl_st_e;

    // status byte as the device presents it, most significant bit first
    typedef struct packed {
        logic ready;
        logic erase_susp;
        logic erase_err;
        logic prog_err;
        logic vpp_low;
        logic prog_susp;
        logic locked;
        logic rsvd;
    } status_t;

    localparam logic [7:0] C_PROG    = 8'h40;
    localparam logic [7:0] C_ERASE   = 8'h20;
    localparam logic [7:0] C_CONFIRM = 8'hD0;
    localparam logic [7:0] C_BUF     = 8'hE8;
    localparam logic [7:0] C_SUSP    = 8'hB0;
    localparam logic [7:0] C_LOCK    = 8'h60;
    localparam logic [7:0] C_LOCKSET = 8'h01;
    localparam logic [7:0] C_CLRSR   = 8'h50;
    localparam logic [7:0] C_ARRAY   = 8'hFF;

    function automatic err_e decode_status(status_t s);
        if (s.erase_err && s.prog_err) return E_CMDSEQ;
        else if (s.vpp_low)            return E_VPP;
        else if (s.erase_err)          return E_ERASE;
        else if (s.prog_err)           return E_PROG;
        else if (s.locked)             return E_LOCKED;
        else                           return E_OK;
    endfunction

    function automatic logic suspendable(op_e op);
        return (op == OP_PROG) || (op == OP_BUFPROG) || (op == OP_ERASE);
    endfunction

endpackage

// File: rtl/fseq_bus.sv
module fseq_bus
    import fseq_pkg::*;
#(
    parameter int AW     = 20,
    parameter int DW     = 16,
    parameter int WE_CYC = 3,
    parameter int RD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_o,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_i
);
    localparam int ACT_MAX = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
    localparam int CTW     = $clog2(ACT_MAX + 1);
    localparam logic [CTW-1:0] WR_LAST = CTW'(WE_CYC - 1);
    localparam logic [CTW-1:0] RD_LAST = CTW'(RD_CYC - 1);

    bus_st_e        st;
    logic [CTW-1:0] cnt;
    logic           rd_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= B_IDLE;
            cnt    <= '0;
            rd_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            rdata  <= '0;
        end else begin
            case (st)
                B_IDLE: if (start) begin
                    rd_q   <= rd;
                    addr_q <= addr;
                    data_q <= wdata;
                    st     <= B_SETUP;
                end
                B_SETUP: begin
                    cnt <= '0;
                    st  <= B_ACT;
                end
                B_ACT: begin
                    cnt <= cnt + 1'b1;
                    if (rd_q && cnt == RD_LAST) rdata <= fl_dq_i;
                    if (cnt == (rd_q ? RD_LAST : WR_LAST)) st <= B_HOLD;
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    assign done     = (st == B_HOLD);
    assign fl_ce_n  = (st == B_IDLE);
    assign fl_we_n  = !((st == B_ACT) && !rd_q);
    assign fl_oe_n  = !((st == B_ACT) && rd_q);
    assign fl_addr  = addr_q;
    assign fl_dq_o  = data_q;
    assign fl_dq_oe = (st != B_IDLE) && !rd_q;

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter int BUF_WORDS = 16,
    parameter int BUF_TRIES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  op_e           req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [$clog2(BUF_WORDS+1)-1:0] req_len,
    output logic          req_ready,
    output logic          done,
    output err_e          err_code,
    output logic [$clog2(BUF_WORDS+1)-1:0] buf_idx,
    input  logic [DW-1:0] buf_data,
    output logic          bus_start,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_done,
    input  logic [DW-1:0] bus_rdata
);
    localparam int LW = $clog2(BUF_WORDS + 1);
    localparam int TW = $clog2(BUF_TRIES + 1);
    localparam logic [TW-1:0] TRY_LAST = TW'(BUF_TRIES - 1);

    ctrl_st_e      st;
    logic          launched;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] idx_q;
    logic [TW-1:0] tries_q;
    status_t       status_q;
    err_e          err_q;
    logic          susp_q;

    status_t rd_stat;
    logic    bus_state;
    logic    poll_busy;
    logic    accept;
    err_e    chk_code;
    logic    unused_hi;

    assign rd_stat   = status_t'(bus_rdata[7:0]);
    assign unused_hi = ^bus_rdata[DW-1:8];
    assign chk_code  = decode_status(status_q);

    function automatic logic [DW-1:0] cb(input logic [7:0] c);
        return DW'(c);
    endfunction

    always_comb begin
        case (st)
            S_CMD1, S_CMD2, S_POLL, S_XSR, S_BCNT, S_BDATA,
            S_SUSP, S_SPOLL, S_RESUME, S_CLR, S_ARRAY: bus_state = 1'b1;
            default:                                   bus_state = 1'b0;
        endcase
    end

    assign poll_busy = (st == S_POLL) && bus_done && !rd_stat.ready;
    assign req_ready = ((st == S_IDLE) && (!susp_q || req_op == OP_RESUME)) ||
                       (poll_busy && req_op == OP_SUSPEND && suspendable(op_q));
    assign accept    = req_valid && req_ready;
    assign bus_start = bus_state && !launched;
    assign done      = (st == S_DONE);
    assign err_code  = err_q;
    assign buf_idx   = idx_q;

    always_comb begin
        bus_rd    = 1'b0;
        bus_addr  = addr_q;
        bus_wdata = '0;
        case (st)
            S_CMD1: case (op_q)
                OP_PROG:    bus_wdata = cb(C_PROG);
                OP_BUFPROG: bus_wdata = cb(C_BUF);
                OP_ERASE:   bus_wdata = cb(C_ERASE);
                default:    bus_wdata = cb(C_LOCK);
            endcase
            S_CMD2: case (op_q)
                OP_PROG:     bus_wdata = data_q;
                OP_LOCK_SET: bus_wdata = cb(C_LOCKSET);
                default:     bus_wdata = cb(C_CONFIRM);
            endcase
            S_POLL, S_SPOLL, S_XSR: bus_rd = 1'b1;
            S_BCNT:   bus_wdata = DW'(len_q - 1'b1);
            S_BDATA: begin
                bus_addr  = addr_q + AW'(idx_q);
                bus_wdata = buf_data;
            end
            S_SUSP:   bus_wdata = cb(C_SUSP);
            S_RESUME: bus_wdata = cb(C_CONFIRM);
            S_CLR:    bus_wdata = cb(C_CLRSR);
            S_ARRAY:  bus_wdata = cb(C_ARRAY);
            default:  bus_wdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            launched <= 1'b0;
            op_q     <= OP_PROG;
            addr_q   <= '0;
            data_q   <= '0;
            len_q    <= '0;
            idx_q    <= '0;
            tries_q  <= '0;
            status_q <= '0;
            err_q    <= E_OK;
            susp_q   <= 1'b0;
        end else begin
            if (bus_start) launched <= 1'b1;
            if (bus_done)  launched <= 1'b0;
            case (st)
                S_IDLE: if (accept) begin
                    case (req_op)
                        OP_SUSPEND: begin
                            err_q <= E_CMDSEQ;
                            st    <= S_CLR;
                        end
                        OP_RESUME: if (susp_q) begin
                            err_q <= E_OK;
                            st    <= S_RESUME;
                        end else begin
                            err_q <= E_CMDSEQ;
                            st    <= S_CLR;
                        end
                        default: begin
                            op_q    <= req_op;
                            addr_q  <= req_addr;
                            data_q  <= req_data;
                            len_q   <= req_len;
                            idx_q   <= '0;
                            tries_q <= '0;
                            err_q   <= E_OK;
                            st      <= S_CMD1;
                        end
                    endcase
                end
                S_CMD1: if (bus_done) st <= (op_q == OP_BUFPROG) ? S_XSR : S_CMD2;
                S_CMD2: if (bus_done) st <= S_POLL;
                S_XSR: if (bus_done) begin
                    if (rd_stat.ready) begin
                        idx_q <= '0;
                        st    <= S_BCNT;
                    end else if (tries_q == TRY_LAST) begin
                        err_q <= E_TIMEOUT;
                        st    <= S_CLR;
                    end else begin
                        tries_q <= tries_q + 1'b1;
                        st      <= S_CMD1;
                    end
                end
                S_BCNT: if (bus_done) st <= S_BDATA;
                S_BDATA: if (bus_done) begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == len_q - 1'b1) st <= S_CMD2;
                end
                S_POLL: if (bus_done) begin
                    if (rd_stat.ready) begin
                        status_q <= rd_stat;
                        st       <= S_CHECK;
                    end else if (accept) begin
                        st <= S_SUSP;
                    end
                end
                S_CHECK: begin
                    err_q <= chk_code;
                    st    <= (chk_code == E_OK) ? S_DONE : S_CLR;
                end
                S_SUSP: if (bus_done) st <= S_SPOLL;
                S_SPOLL: if (bus_done && rd_stat.ready) begin
                    if (rd_stat.erase_susp || rd_stat.prog_susp) begin
                        susp_q <= 1'b1;
                        err_q  <= E_SUSPENDED;
                        st     <= S_ARRAY;
                    end else begin
                        status_q <= rd_stat;
                        st       <= S_CHECK;
                    end
                end
                S_RESUME: if (bus_done) begin
                    susp_q <= 1'b0;
                    st     <= S_POLL;
                end
                S_CLR:   if (bus_done) st <= S_ARRAY;
                S_ARRAY: if (bus_done) st <= S_DONE;
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import fseq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter int WE_CYC    = 3,
    parameter int RD_CYC    = 2,
    parameter int BUF_WORDS = 16,
    parameter int BUF_TRIES = 4,
    localparam int LW       = $clog2(BUF_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [LW-1:0] req_len,
    output logic          req_ready,
    output logic          done,
    output logic [2:0]    err_code,
    output logic [LW-1:0] buf_idx,
    input  logic [DW-1:0] buf_data,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_o,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_i
);
    logic          bus_start;
    logic          bus_rd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_done;
    logic [DW-1:0] bus_rdata;
    err_e          code;

    fseq_ctrl #(
        .AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS), .BUF_TRIES(BUF_TRIES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (op_e'(req_op)),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .req_len   (req_len),
        .req_ready (req_ready),
        .done      (done),
        .err_code  (code),
        .buf_idx   (buf_idx),
        .buf_data  (buf_data),
        .bus_start (bus_start),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata)
    );

    assign err_code = code;

    fseq_bus #(
        .AW(AW), .DW(DW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .start    (bus_start),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .done     (bus_done),
        .rdata    (bus_rdata),
        .fl_ce_n  (fl_ce_n),
        .fl_oe_n  (fl_oe_n),
        .fl_we_n  (fl_we_n),
        .fl_addr  (fl_addr),
        .fl_dq_o  (fl_dq_o),
        .fl_dq_oe (fl_dq_oe),
        .fl_dq_i  (fl_dq_i)
    );

endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk #(
    parameter int AW     = 20,
    parameter int DW     = 16,
    parameter int WE_CYC = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_we_n,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dq_o,
    input logic          fl_dq_oe,
    input logic          done,
    input logic          req_ready
);
    logic [15:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst)           wcnt <= '0;
        else if (!fl_we_n) wcnt <= wcnt + 1'b1;
        else               wcnt <= '0;
    end

    a_r11_we_in_ce: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> !fl_ce_n);

    a_r11_rw_excl: assert property (@(posedge clk) disable iff (rst)
        fl_oe_n || fl_we_n);

    a_r11_we_width: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> (wcnt == 16'(WE_CYC)));

    a_r11_ce_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_we_n) |-> $past(!fl_ce_n));

    a_r11_ce_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> !fl_ce_n);

    a_r11_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));

    a_r11_data_stable: assert property (@(posedge clk) disable iff (rst)
        (!fl_ce_n && $past(!fl_ce_n) && fl_dq_oe) |-> $stable(fl_dq_o));

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r1_done_bus_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> fl_ce_n);

    a_r9_no_take_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_ready);

endmodule

bind flash_pe_seq flash_pe_seq_chk #(.AW(AW), .DW(DW), .WE_CYC(WE_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n),
    .fl_addr   (fl_addr),
    .fl_dq_o   (fl_dq_o),
    .fl_dq_oe  (fl_dq_oe),
    .done      (done),
    .req_ready (req_ready)
);

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int WE_CYC = 3;
    localparam int BUF_WORDS = 16;
    localparam int BUF_TRIES = 4;
    localparam int LW = $clog2(BUF_WORDS + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_ready, done;
    logic [2:0]    err_code;
    logic [LW-1:0] buf_idx;
    logic [DW-1:0] buf_data;
    logic          fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_o, fl_dq_i;

    always #5 clk = ~clk;

    flash_pe_seq u_flash_pe_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
        .req_ready(req_ready), .done(done), .err_code(err_code),
        .buf_idx(buf_idx), .buf_data(buf_data), .fl_ce_n(fl_ce_n),
        .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
        .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
    );

    int nchk = 0;
    int nerr = 0;

    // requester buffer
    assign buf_data = 16'h1100 + DW'(buf_idx);

    // behavioural flash device
    int            busy_left = 0;
    int            xsr_wait = 0;
    int            resume_busy = 2;
    logic [7:0]    sr_err = 8'h00;
    logic          susp = 1'b0;
    logic [7:0]    last_cmd = 8'h00;
    logic [DW-1:0] rd_val = '0;
    logic [AW-1:0] la [0:63];
    logic [DW-1:0] ld [0:63];
    int            nw = 0;
    int            nsr = 0;
    int            welow = 0;
    int            we_bad = 0;

    assign fl_dq_i = (fl_oe_n === 1'b0) ? rd_val : '0;

    always @(posedge fl_we_n) begin
        if (fl_ce_n === 1'b0 && rst === 1'b0) begin
            if (nw < 64) begin
                la[nw] = fl_addr;
                ld[nw] = fl_dq_o;
            end
            nw++;
            if (fl_dq_o == 16'h00B0) begin
                busy_left = 1;
                susp = 1'b1;
            end else if (fl_dq_o == 16'h00D0 && susp) begin
                susp = 1'b0;
                busy_left = resume_busy;
            end else if (fl_dq_o == 16'h0050) begin
                sr_err = 8'h00;
            end
            last_cmd = fl_dq_o[7:0];
        end
    end

    always @(negedge fl_oe_n) begin
        if (fl_ce_n === 1'b0) begin
            if (last_cmd == 8'hE8) begin
                if (xsr_wait > 0) begin
                    xsr_wait--;
                    rd_val = 16'h0000;
                end else begin
                    rd_val = 16'h0080;
                end
            end else begin
                nsr++;
                if (busy_left > 0) begin
                    busy_left--;
                    rd_val = 16'h0000;
                end else begin
                    rd_val = {8'h00, 8'h80 | sr_err | (susp ? 8'h40 : 8'h00)};
                end
            end
        end
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (fl_we_n === 1'b0) welow++;
            else if (welow != 0) begin
                if (welow != WE_CYC) we_bad++;
                welow = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        nw = 0;
        nsr = 0;
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [LW-1:0] n);
        @(negedge clk);
        req_op = op; req_addr = a; req_data = d; req_len = n;
        req_valid = 1'b1;
        while (req_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [2:0] code);
        while (done !== 1'b1) @(negedge clk);
        code = err_code;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ce_n", fl_ce_n, 1);
        chk("R1 we_n", fl_we_n, 1);
        chk("R1 oe_n", fl_oe_n, 1);
        chk("R1 done", done, 0);
        chk("R1 err_code", err_code, 0);
        chk("R1 req_ready", req_ready, 1);
    endtask

    task automatic t_word_prog();
        logic [2:0] c;
        clear_log(); busy_left = 3; sr_err = 8'h00;
        issue(3'd0, 20'h01234, 16'h5A5A, '0);
        wait_done(c);
        chk("R2 code", c, 0);
        chk("R2 R8 write count", nw, 2);
        chk("R2 cmd", ld[0], 16'h0040);
        chk("R2 cmd addr", la[0], 20'h01234);
        chk("R2 data", ld[1], 16'h5A5A);
        chk("R2 data addr", la[1], 20'h01234);
        chk("R2 status reads", nsr, 4);
    endtask

    task automatic t_erase();
        logic [2:0] c;
        clear_log(); busy_left = 2;
        issue(3'd2, 20'h40000, '0, '0);
        wait_done(c);
        chk("R3 code", c, 0);
        chk("R3 write count", nw, 2);
        chk("R3 setup", ld[0], 16'h0020);
        chk("R3 confirm", ld[1], 16'h00D0);
        chk("R3 confirm addr", la[1], 20'h40000);
        chk("R3 status reads", nsr, 3);
    endtask

    task automatic t_locks();
        logic [2:0] c;
        clear_log(); busy_left = 1;
        issue(3'd5, 20'h20000, '0, '0);
        wait_done(c);
        chk("R4 set code", c, 0);
        chk("R4 set count", nw, 2);
        chk("R4 set first", ld[0], 16'h0060);
        chk("R4 set second", ld[1], 16'h0001);
        clear_log(); busy_left = 1;
        issue(3'd6, 20'h00000, '0, '0);
        wait_done(c);
        chk("R4 clr code", c, 0);
        chk("R4 clr first", ld[0], 16'h0060);
        chk("R4 clr second", ld[1], 16'h00D0);
    endtask

    task automatic t_buffered();
        logic [2:0] c;
        clear_log(); busy_left = 2; xsr_wait = 2;
        issue(3'd1, 20'h60010, '0, LW'(4));
        wait_done(c);
        chk("R5 code", c, 0);
        chk("R5 write count", nw, 9);
        for (int i = 0; i < 3; i++) chk("R5 query cmd", ld[i], 16'h00E8);
        chk("R5 count word", ld[3], 16'h0003);
        for (int i = 0; i < 4; i++) begin
            chk("R5 data", ld[4+i], 16'h1100 + DW'(i));
            chk("R5 data addr", la[4+i], 20'h60010 + AW'(i));
        end
        chk("R5 confirm", ld[8], 16'h00D0);
    endtask

    task automatic t_buf_timeout();
        logic [2:0] c;
        clear_log(); xsr_wait = 10;
        issue(3'd1, 20'h60000, '0, LW'(2));
        wait_done(c);
        chk("R6 code", c, 6);
        chk("R6 write count", nw, BUF_TRIES + 2);
        chk("R6 last query", ld[BUF_TRIES-1], 16'h00E8);
        chk("R8 clear status", ld[BUF_TRIES], 16'h0050);
        chk("R8 read array", ld[BUF_TRIES+1], 16'h00FF);
        xsr_wait = 0;
    endtask

    task automatic t_err(input logic [7:0] sr, input logic [2:0] exp, input string tag);
        logic [2:0] c;
        clear_log(); busy_left = 1; sr_err = sr;
        issue(3'd0, 20'h00100, 16'h0123, '0);
        wait_done(c);
        chk(tag, c, exp);
        chk("R8 count after error", nw, 4);
        chk("R8 clear status", ld[2], 16'h0050);
        chk("R8 read array", ld[3], 16'h00FF);
    endtask

    task automatic t_suspend_resume();
        logic [2:0] c;
        clear_log(); busy_left = 1000; resume_busy = 2;
        issue(3'd2, 20'h80000, '0, '0);
        issue(3'd3, '0, '0, '0);
        wait_done(c);
        chk("R9 code", c, 7);
        chk("R9 write count", nw, 4);
        chk("R9 suspend cmd", ld[2], 16'h00B0);
        chk("R9 read array", ld[3], 16'h00FF);
        @(negedge clk);
        req_op = 3'd0;
        #1 chk("R9 only resume taken", req_ready, 0);
        req_op = 3'd4;
        #1 chk("R9 resume taken", req_ready, 1);
        issue(3'd4, '0, '0, '0);
        wait_done(c);
        chk("R10 code", c, 0);
        chk("R10 write count", nw, 5);
        chk("R10 resume cmd", ld[4], 16'h00D0);
        chk("R10 resume addr", la[4], 20'h80000);
    endtask

    task automatic t_race();
        logic [2:0] c;
        clear_log(); busy_left = 0; sr_err = 8'h00;
        issue(3'd0, 20'h00200, 16'h0321, '0);
        req_op = 3'd3; req_valid = 1'b1;
        wait_done(c);
        chk("R9 ready poll wins code", c, 0);
        chk("R9 ready poll wins writes", nw, 2);
        chk("R9 pending suspend taken in idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(c);
        chk("R12 idle suspend code", c, 2);
        chk("R12 idle suspend writes", nw, 4);
        chk("R12 clear status", ld[2], 16'h0050);
    endtask

    task automatic t_resume_idle();
        logic [2:0] c;
        clear_log();
        issue(3'd4, '0, '0, '0);
        wait_done(c);
        chk("R12 resume idle code", c, 2);
        chk("R12 resume idle writes", nw, 2);
        chk("R12 first write", ld[0], 16'h0050);
        chk("R12 second write", ld[1], 16'h00FF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_word_prog();
        t_erase();
        t_locks();
        t_buffered();
        t_buf_timeout();
        t_err(8'h30, 3'd2, "R7 both error bits");
        t_err(8'h38, 3'd2, "R7 cmdseq over voltage");
        t_err(8'h28, 3'd1, "R7 voltage over erase");
        t_err(8'h20, 3'd3, "R7 erase error");
        t_err(8'h12, 3'd4, "R7 program over locked");
        t_err(8'h02, 3'd5, "R7 locked");
        t_suspend_resume();
        t_race();
        t_resume_idle();
        chk("R11 write pulse widths", we_bad, 0);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule